// File: doc/BRIEF.md
# Port Pin Handshake Multiplexer

This block sits between a four-bit latched output port and its external pins. After reset the pins simply follow the port latch. Two one-cycle mode strobes can then turn some of the pins into handshake signals. One strobe routes the buffer status flags to two of the pins. The other strobe turns a third pin into a DMA request and a fourth pin into an acknowledge input. Once a mode is on, a local write to the port latch takes on a new meaning: it enables or gates a handshake output, or it raises a request.

The host bus strobes `rd_stb` and `wr_stb` are one-cycle pulses that mark the trailing edge of a host access. `dack_n` is the active-low DMA acknowledge. It is sampled by the block. The buffer logic and the instruction decoder that produce the flags and the mode strobes sit outside this block. Port data bit k (k = 0..3) belongs to pin k: bit 0 is the output-full pin, bit 1 the input-ready pin, bit 2 the request pin and bit 3 the acknowledge pin.

Top module: `hs_port_pins`

## Requirements
- R1: While `rst` is high, and on the cycle after it, the latch holds `4'hF`. Then `pin_out` = `4'hF`, `pin_oe` = `4'hF`, both modes are off and the request is clear.
- R2: With no mode on, a `port_wr` with data D makes `pin_out` = D after the next rising edge, and every pin stays driven.
- R3: After an `en_flags` pulse, pin 0 outputs `latch[0] & obf`. Latch bit 0 set to 1 passes the output-full flag, and 0 forces the pin low.
- R4: In flags mode, pin 1 outputs `latch[1] & ~ibf`. Latch bit 1 set to 1 shows "ready for data" as the inverse of the input-full flag, and 0 forces the pin low.
- R5: Flags mode leaves pins 2 and 3 as plain latch outputs.
- R6: After an `en_dma` pulse, pin 2 outputs the request flop. Pin 3 becomes an input: `pin_oe[3]` = 0 and `pin_out[3]` = 0.
- R7: In DMA mode, a `port_wr` with data bit 2 = 1 sets the request, which is visible on pin 2 after the next edge.
- R8: An acknowledged read (`dack_n` = 0 with `rd_stb` = 1) clears the request.
- R9: An acknowledged write (`dack_n` = 0 with `wr_stb` = 1) clears the request.
- R10: A further `en_dma` pulse clears the request.
- R11: Writing 0 to data bit 2 has no effect on the request. A bus strobe with `dack_n` = 1 also leaves it set.
- R12: When a set and a clear occur in the same cycle, the clear wins.
- R13: Each mode stays on until reset. The two modes are independent: DMA mode alone leaves pins 0 and 1 as plain latch outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Local write to the port latch |
| port_wdata | input | 4 | Port write data, bit k for pin k |
| en_flags | input | 1 | Pulse: turn on flags mode |
| en_dma | input | 1 | Pulse: turn on DMA mode and clear the request |
| obf | input | 1 | Output buffer full status |
| ibf | input | 1 | Input buffer full status |
| rd_stb | input | 1 | Host read completed pulse |
| wr_stb | input | 1 | Host write completed pulse |
| dack_n | input | 1 | DMA acknowledge, active low |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The checker watches a fixed set of properties on every cycle. It checks that the request is set and cleared one edge after its cause, that the acknowledge pin is never driven in DMA mode, that the modes never drop before reset, and that plain port writes reach the pins. Other behaviour shows only in the bench's scenarios. This covers the flag gating and inversion across all obf/ibf combinations, the reset image of the pins, a set and a clear landing in the same cycle, and DMA mode on its own leaving the flag pins plain.

// File: rtl/hs_pin_pkg.sv
package hs_pin_pkg;

    localparam int PORT_W  = 4;
    localparam int PIN_OBF = 0;
    localparam int PIN_IBF = 1;
    localparam int PIN_DRQ = 2;
    localparam int PIN_ACK = 3;

    typedef struct packed {
        logic flags;
        logic dma;
    } mode_t;

    typedef struct packed {
        logic [PORT_W-1:0] val;
        logic [PORT_W-1:0] oe;
    } pin_drive_t;

    // enable bit from the latch gates a status level onto a pin
    function automatic logic gate_level(input logic enable, input logic level);
        return enable & level;
    endfunction

endpackage

// File: rtl/hs_mode_reg.sv
module hs_mode_reg
    import hs_pin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_flags,
    input  logic  en_dma,
    output mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else begin
            if (en_flags) mode.flags <= 1'b1;
            if (en_dma)   mode.dma   <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_port_latch.sv
module hs_port_latch #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/hs_drq_ctl.sv
module hs_drq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic dma_on,
    input  logic en_dma,
    input  logic set_req,
    input  logic dack_n,
    input  logic rd_stb,
    input  logic wr_stb,
    output logic drq
);
    logic ack_cycle;
    logic clr;
    logic set;

    always_comb begin
        ack_cycle = !dack_n && (rd_stb || wr_stb);
        clr       = en_dma || (dma_on && ack_cycle);
        set       = dma_on && set_req;
    end

    // clear has priority over set
    always_ff @(posedge clk) begin
        if (rst)      drq <= 1'b0;
        else if (clr) drq <= 1'b0;
        else if (set) drq <= 1'b1;
    end
endmodule

// File: rtl/hs_pin_mux.sv
module hs_pin_mux
    import hs_pin_pkg::*;
(
    input  mode_t             mode,
    input  logic [PORT_W-1:0] latch,
    input  logic              obf,
    input  logic              ibf,
    input  logic              drq,
    output pin_drive_t        drive
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i == PIN_OBF) begin : g_obf
            always_comb begin
                drive.val[i] = mode.flags ? gate_level(latch[i], obf) : latch[i];
                drive.oe[i]  = 1'b1;
            end
        end else if (i == PIN_IBF) begin : g_ibf
            always_comb begin
                drive.val[i] = mode.flags ? gate_level(latch[i], !ibf) : latch[i];
                drive.oe[i]  = 1'b1;
            end
        end else if (i == PIN_DRQ) begin : g_drq
            always_comb begin
                drive.val[i] = mode.dma ? drq : latch[i];
                drive.oe[i]  = 1'b1;
            end
        end else begin : g_ack
            always_comb begin
                drive.val[i] = mode.dma ? 1'b0 : latch[i];
                drive.oe[i]  = !mode.dma;
            end
        end
    end
endmodule

// File: rtl/hs_port_pins.sv
module hs_port_pins
    import hs_pin_pkg::*;
#(
    parameter logic [PORT_W-1:0] LATCH_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_wdata,
    input  logic              en_flags,
    input  logic              en_dma,
    input  logic              obf,
    input  logic              ibf,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              dack_n,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    mode_t             mode_q;
    logic [PORT_W-1:0] latch_q;
    logic              drq_q;
    pin_drive_t        drive;

    hs_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .en_flags (en_flags),
        .en_dma   (en_dma),
        .mode     (mode_q)
    );

    hs_port_latch #(.W(PORT_W), .RST_VAL(LATCH_RST)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .wr    (port_wr),
        .wdata (port_wdata),
        .q     (latch_q)
    );

    hs_drq_ctl u_drq (
        .clk     (clk),
        .rst     (rst),
        .dma_on  (mode_q.dma),
        .en_dma  (en_dma),
        .set_req (port_wr && port_wdata[PIN_DRQ]),
        .dack_n  (dack_n),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .drq     (drq_q)
    );

    hs_pin_mux u_mux (
        .mode  (mode_q),
        .latch (latch_q),
        .obf   (obf),
        .ibf   (ibf),
        .drq   (drq_q),
        .drive (drive)
    );

    assign pin_out = drive.val;
    assign pin_oe  = drive.oe;
endmodule

// File: rtl/hs_port_pins_chk.sv
module hs_port_pins_chk (
    input logic       clk,
    input logic       rst,
    input logic       port_wr,
    input logic [3:0] port_wdata,
    input logic       en_flags,
    input logic       en_dma,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic       dack_n,
    input logic       flags_on,
    input logic       dma_on,
    input logic [3:0] pin_out,
    input logic [3:0] pin_oe
);
    logic ack_now;
    assign ack_now = !dack_n && (rd_stb || wr_stb);

    AST_PORT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!flags_on && !dma_on && !en_flags && !en_dma && port_wr)
        |=> (pin_out == $past(port_wdata)) && (pin_oe == 4'hF)); // R2

    AST_ACK_PIN_INPUT: assert property (@(posedge clk) disable iff (rst)
        dma_on |-> !pin_oe[3]); // R6

    AST_DRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (dma_on && port_wr && port_wdata[2] && !en_dma && !ack_now)
        |=> pin_out[2]); // R7

    AST_DRQ_CLR_RD: assert property (@(posedge clk) disable iff (rst)
        (dma_on && !dack_n && rd_stb) |=> !pin_out[2]); // R8

    AST_DRQ_CLR_WR: assert property (@(posedge clk) disable iff (rst)
        (dma_on && !dack_n && wr_stb) |=> !pin_out[2]); // R9

    AST_DRQ_CLR_EN: assert property (@(posedge clk) disable iff (rst)
        en_dma |=> !pin_out[2]); // R10

    AST_DRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dma_on && pin_out[2] && !en_dma && dack_n) |=> pin_out[2]); // R11

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (dma_on || flags_on) |=> ($past(dma_on) -> dma_on) && ($past(flags_on) -> flags_on)); // R13
endmodule

bind hs_port_pins hs_port_pins_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .en_flags   (en_flags),
    .en_dma     (en_dma),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .dack_n     (dack_n),
    .flags_on   (mode_q.flags),
    .dma_on     (mode_q.dma),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/hs_port_pins_test.sv
module hs_port_pins_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_wr = 1'b0;
    logic [3:0] port_wdata = '0;
    logic       en_flags = 1'b0;
    logic       en_dma = 1'b0;
    logic       obf = 1'b0;
    logic       ibf = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic       dack_n = 1'b1;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    typedef struct {
        logic [3:0] exp_out;
        logic [3:0] exp_oe;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_port_pins uut (
        .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata),
        .en_flags(en_flags), .en_dma(en_dma), .obf(obf), .ibf(ibf),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .dack_n(dack_n),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // driver: set inputs for one cycle and queue the expected pins
    task automatic step(input bit r, input bit pw, input logic [3:0] wd,
                        input bit ef, input bit ed, input bit o, input bit i,
                        input bit rd, input bit wr, input bit dn,
                        input logic [3:0] eo, input logic [3:0] ee, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; port_wr = pw; port_wdata = wd; en_flags = ef; en_dma = ed;
        obf = o; ibf = i; rd_stb = rd; wr_stb = wr; dack_n = dn;
        e.exp_out = eo; e.exp_oe = ee; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (pin_out !== e.exp_out || pin_oe !== e.exp_oe) begin
                    n_bad++;
                    $display("FAIL %s: pin_out=%h pin_oe=%h expected pin_out=%h pin_oe=%h",
                             e.tag, pin_out, pin_oe, e.exp_out, e.exp_oe);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*2000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        //    rst pw wd    ef ed obf ibf rd wr dn  out   oe
        step(1, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, 4'hF, "R1 reset image");
        step(0, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, 4'hF, "R1 after reset");
        step(0, 1, 4'h5, 0, 0, 0, 0, 0, 0, 1, 4'h5, 4'hF, "R2 write 5");
        step(0, 1, 4'hA, 0, 0, 0, 0, 0, 0, 1, 4'hA, 4'hF, "R2 write A");
        step(0, 1, 4'h3, 0, 0, 1, 0, 0, 0, 1, 4'h3, 4'hF, "R2 flags ignored");
        step(0, 0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 4'h2, 4'hF, "R3 flags on obf=0");
        step(0, 0, 4'h0, 0, 0, 1, 0, 0, 0, 1, 4'h3, 4'hF, "R3 obf=1 passes");
        step(0, 0, 4'h0, 0, 0, 1, 1, 0, 0, 1, 4'h1, 4'hF, "R4 ibf=1 inverted");
        step(0, 1, 4'h0, 0, 0, 1, 0, 0, 0, 1, 4'h0, 4'hF, "R3 R4 gated low");
        step(0, 1, 4'hC, 0, 0, 1, 0, 0, 0, 1, 4'hC, 4'hF, "R5 pins 2 3 plain");
        step(0, 0, 4'h0, 0, 1, 1, 0, 0, 0, 1, 4'h0, 4'h7, "R6 dma on");
        step(0, 1, 4'h4, 0, 0, 1, 0, 0, 0, 1, 4'h4, 4'h7, "R7 drq set");
        step(0, 1, 4'h0, 0, 0, 1, 0, 0, 0, 1, 4'h4, 4'h7, "R11 write 0 keeps drq");
        step(0, 0, 4'h0, 0, 0, 1, 0, 1, 0, 1, 4'h4, 4'h7, "R11 rd without dack");
        step(0, 0, 4'h0, 0, 0, 1, 0, 1, 0, 0, 4'h0, 4'h7, "R8 dack rd clears");
        step(0, 1, 4'h4, 0, 0, 1, 0, 0, 0, 1, 4'h4, 4'h7, "R7 drq set again");
        step(0, 0, 4'h0, 0, 0, 1, 0, 0, 1, 0, 4'h0, 4'h7, "R9 dack wr clears");
        step(0, 1, 4'h4, 0, 0, 1, 0, 0, 0, 1, 4'h4, 4'h7, "R7 drq set third");
        step(0, 0, 4'h0, 0, 1, 1, 0, 0, 0, 1, 4'h0, 4'h7, "R10 en_dma clears");
        step(0, 1, 4'h7, 0, 0, 1, 0, 0, 1, 0, 4'h3, 4'h7, "R12 clear beats set");
        step(0, 0, 4'h0, 0, 0, 1, 0, 0, 0, 1, 4'h3, 4'h7, "R13 modes sticky");
        step(1, 0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, 4'hF, "R1 R13 reset clears modes");
        step(0, 1, 4'h4, 0, 0, 0, 0, 0, 1, 0, 4'h4, 4'hF, "R13 port mode after reset");
        step(0, 0, 4'h0, 0, 1, 0, 1, 0, 0, 1, 4'h0, 4'h7, "R13 dma only");
        step(0, 1, 4'h3, 0, 0, 0, 1, 0, 0, 1, 4'h3, 4'h7, "R13 flag pins plain");
        step(0, 0, 4'h0, 0, 0, 0, 1, 0, 0, 1, 4'h3, 4'h7, "R13 idle");
        @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule